// File: doc/BRIEF.md
# Filtered Edge Capture Channel

This block holds a set of input-capture channels (two by default) that record the value of an external timer when a pin changes state. Each channel synchronizes its asynchronous pin and can pass it through a run-length noise filter. It picks out either the rising or the falling transition and counts those transitions. On the programmed count it copies the timer into its own capture register and raises a sticky flag. The flags of all channels are merged into one interrupt request.

The timer itself and any register decode stay outside the block. Software programs polarity, filter enable and event count per channel on plain input pins and clears a flag with a one-cycle pulse. After reset the synchronizers, the filtered level and the previous-level register all read low. A pin held high while reset is released therefore produces one rising transition.

Top module: `cap_unit`

## Requirements
- R1: While reset is asserted and right after it, every capture register reads 0, every flag reads 0 and the interrupt output reads 0.
- R2: With the channel's polarity bit at 0 and the filter off, a rising pin transition causes a capture. The capture register then holds the timer value present at the third rising clock edge after the edge that first samples the new pin level. Falling transitions cause no capture.
- R3: With the polarity bit at 1, the same applies to falling transitions, and rising transitions cause no capture.
- R4: With the filter-enable bit at 1, a new level counts only after four consecutive samples at that level. A qualifying transition is then captured with timer value T+6, where T is the timer value at the first sampling edge. A pulse shorter than four samples is ignored: no flag and no change of the capture register.
- R5: The 4-bit event count N makes a capture happen on every N-th qualifying transition, and the count restarts after each capture. N=0 and N=1 both capture on every qualifying transition. The count starts from zero after reset.
- R6: A capture sets the channel's flag. The flag stays at 1 until a clear pulse on that channel's clear bit, which drops it at the next clock edge.
- R7: A capture while the flag is already 1 overwrites the capture register and leaves the flag at 1. A capture in the same cycle as a clear leaves the flag at 1.
- R8: The interrupt output is 1 whenever any channel's flag is 1, and 0 when all flags are 0.
- R9: Channels are independent. Activity on one channel's pin changes neither the register nor the flag of another channel.
- R10: With the filter off, a pin pulse one clock long is enough to trigger a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all channels |
| rst_n | input | 1 | Active-low reset |
| pin_i | input | NCH | Raw asynchronous capture pins, one bit per channel |
| tmr_i | input | TW | Running timer value to be captured |
| edge_fall_i | input | NCH | Polarity per channel: 0 rising, 1 falling |
| filt_en_i | input | NCH | Noise filter enable per channel |
| evt_cnt_i | input | NCH*EVW | Event count per channel, channel c at bits c*EVW upward |
| flag_clr_i | input | NCH | Flag clear pulse per channel |
| cap_val_o | output | NCH*TW | Capture registers, channel c at bits c*TW upward |
| cap_flag_o | output | NCH | Sticky capture flags |
| irq_o | output | 1 | Merged interrupt request |

## Verification
On every cycle the assertions check that a capture strobe loads the register with the timer value of that cycle and sets the flag. They also check that the register never moves without a strobe, that a flag only falls on a clear, and that any set flag drives the interrupt. Only the bench scenarios can show the pin-to-capture latency with and without the filter, the rejection of short glitches, and the every-N-th-transition counting with its restart. A sweep over channel, polarity, filter and event counts 0 to 3 covers these, together with directed cases for overwrite, clear-versus-capture collisions and two channels running at once.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   // pick the transition of interest from the rising/falling pair
   function automatic logic pick_edge(edge_sel_e sel, logic rise, logic fall);
      return (sel == EDGE_FALL) ? fall : rise;
   endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic d_i,
   output logic lvl_o
);

   if (LEN < 1) begin : g_bad_len
      $error("cap_filter: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_plain
      // a run length of one is no filter at all
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= 1'b0;
         else        lvl_q <= d_i;
      end
      assign lvl_o = lvl_q;
      logic unused_en;
      assign unused_en = en_i;
   end else begin : g_run
      localparam int CW = $clog2(LEN);
      localparam logic [CW-1:0] LAST = CW'(LEN - 1);

      logic          lvl_q;
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
         end else if (!en_i) begin
            lvl_q <= d_i;
            run_q <= '0;
         end else if (d_i == lvl_q) begin
            run_q <= '0;
         end else if (run_q == LAST) begin
            lvl_q <= d_i;
            run_q <= '0;
         end else begin
            run_q <= run_q + CW'(1);
         end
      end

      assign lvl_o = lvl_q;
   end

endmodule

// File: rtl/cap_event.sv
module cap_event
   import cap_pkg::*;
#(
   parameter int EVW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           lvl_i,
   input  edge_sel_e      sel_i,
   input  logic [EVW-1:0] evt_n_i,
   output logic           fire_o
);

   if (EVW < 1) begin : g_bad_evw
      $error("cap_event: EVW must be at least 1");
   end

   logic           lvl_d_q;
   logic [EVW-1:0] seen_q;
   logic           rise, fall, qual, last;
   logic [EVW:0]   seen_nx;

   assign rise    = lvl_i & ~lvl_d_q;
   assign fall    = ~lvl_i & lvl_d_q;
   assign qual    = pick_edge(sel_i, rise, fall);
   assign seen_nx = {1'b0, seen_q} + (EVW+1)'(1);
   // a count of 0 behaves like 1; a count lowered below progress fires at once
   assign last    = (seen_nx >= {1'b0, evt_n_i});
   assign fire_o  = qual & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_d_q <= 1'b0;
         seen_q  <= '0;
      end else begin
         lvl_d_q <= lvl_i;
         if (qual) seen_q <= last ? '0 : seen_nx[EVW-1:0];
      end
   end

endmodule

// File: rtl/cap_unit.sv
module cap_unit
   import cap_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int TW          = 16,
   parameter int EVW         = 4,
   parameter int FILT_LEN    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    pin_i,
   input  logic [TW-1:0]     tmr_i,
   input  logic [NCH-1:0]    edge_fall_i,
   input  logic [NCH-1:0]    filt_en_i,
   input  logic [NCH*EVW-1:0] evt_cnt_i,
   input  logic [NCH-1:0]    flag_clr_i,
   output logic [NCH*TW-1:0] cap_val_o,
   output logic [NCH-1:0]    cap_flag_o,
   output logic              irq_o
);

   if (NCH < 1) begin : g_bad_nch
      $error("cap_unit: NCH must be at least 1");
   end
   if (TW < 1) begin : g_bad_tw
      $error("cap_unit: TW must be at least 1");
   end

   logic [NCH-1:0] cap_fire;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic          pin_s;
      logic          lvl;
      logic [TW-1:0] val_q;
      logic          flag_q;

      cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[c]),
         .q_o   (pin_s)
      );

      cap_filter #(.LEN(FILT_LEN)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (filt_en_i[c]),
         .d_i   (pin_s),
         .lvl_o (lvl)
      );

      cap_event #(.EVW(EVW)) u_evt (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl),
         .sel_i   (edge_sel_e'(edge_fall_i[c])),
         .evt_n_i (evt_cnt_i[c*EVW +: EVW]),
         .fire_o  (cap_fire[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            flag_q <= 1'b0;
         end else begin
            if (cap_fire[c]) val_q <= tmr_i;
            if (cap_fire[c])        flag_q <= 1'b1;
            else if (flag_clr_i[c]) flag_q <= 1'b0;
         end
      end

      assign cap_val_o[c*TW +: TW] = val_q;
      assign cap_flag_o[c]         = flag_q;
   end

   assign irq_o = |cap_flag_o;

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
   parameter int NCH = 2,
   parameter int TW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NCH-1:0]    fire,
   input logic [TW-1:0]     tmr,
   input logic [NCH-1:0]    clr,
   input logic [NCH*TW-1:0] cap_val,
   input logic [NCH-1:0]    flag,
   input logic              irq
);

   for (genvar i = 0; i < NCH; i++) begin : g_c
      // R2
      cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |=> cap_val[i*TW +: TW] == $past(tmr));
      // R9
      cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !fire[i] |=> $stable(cap_val[i*TW +: TW]));
      // R7
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fire[i] |=> flag[i]);
      // R6
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag[i] && !clr[i] |=> flag[i]);
      // R6
      flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && !fire[i] |=> !flag[i]);
      // R8
      irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
         flag[i] |-> irq);
   end

   // R8
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag == '0 |-> !irq);

endmodule

bind cap_unit cap_unit_chk #(.NCH(NCH), .TW(TW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .fire    (cap_fire),
   .tmr     (tmr_i),
   .clr     (flag_clr_i),
   .cap_val (cap_val_o),
   .flag    (cap_flag_o),
   .irq     (irq_o)
);

// File: tb/cap_unit_bench.sv
module cap_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 2;
   localparam int TW  = 16;
   localparam int EVW = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [NCH-1:0]    pin;
   logic [TW-1:0]     tmr;
   logic [NCH-1:0]    fall;
   logic [NCH-1:0]    filt;
   logic [NCH*EVW-1:0] evt;
   logic [NCH-1:0]    clr;
   logic [NCH*TW-1:0] cap_val;
   logic [NCH-1:0]    cap_flag;
   logic              irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cap_unit #(.NCH(NCH), .TW(TW), .EVW(EVW), .FILT_LEN(4), .SYNC_STAGES(2)) u_cap_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .tmr_i       (tmr),
      .edge_fall_i (fall),
      .filt_en_i   (filt),
      .evt_cnt_i   (evt),
      .flag_clr_i  (clr),
      .cap_val_o   (cap_val),
      .cap_flag_o  (cap_flag),
      .irq_o       (irq)
   );

   // every wait goes through here; the timer advances once per clock
   task automatic tick();
      @(negedge clk);
      tmr = tmr + 1'b1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] cap(int ch);
      return cap_val[ch*TW +: TW];
   endfunction

   task automatic do_reset();
      pin   = '0;
      rst_n = 1'b0;
      ticks(2);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [TW-1:0] t, t2, exp_val;
      int cnt, nef, lat;
      bit exp_flag, lvl, qual;

      rst_n = 1'b0; pin = '0; tmr = '0; fall = '0; filt = '0; evt = '0; clr = '0;
      ticks(2);
      check("R1 cap0 in reset", cap(0), 0);
      check("R1 cap1 in reset", cap(1), 0);
      check("R1 flags in reset", cap_flag, 0);
      check("R1 irq in reset", irq, 0);
      rst_n = 1'b1;
      tick();
      check("R1 flags after reset", cap_flag, 0);

      // sweep: channel x polarity x filter x event count (R2 R3 R4 R5 R6 R8 R9)
      for (int ch = 0; ch < NCH; ch++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int f = 0; f < 2; f++) begin
               for (int n = 0; n < 4; n++) begin
                  fall = '0; filt = '0; evt = '0;
                  fall[ch] = pol[0];
                  filt[ch] = f[0];
                  evt[ch*EVW +: EVW] = EVW'(n);
                  do_reset();
                  cnt = 0;
                  nef = (n == 0) ? 1 : n;
                  lat = f ? 6 : 3;
                  exp_flag = 1'b0;
                  exp_val  = '0;
                  for (int p = 0; p < 6; p++) begin
                     lvl = (p % 2 == 0);
                     pin[ch] = lvl;
                     t = tmr;
                     ticks(10);
                     qual = (lvl != pol[0]);
                     if (qual) begin
                        cnt++;
                        if (cnt % nef == 0) begin
                           exp_flag = 1'b1;
                           exp_val  = t + TW'(lat);
                        end
                     end
                     check(pol ? "R3 flag" : "R2 flag", cap_flag[ch], exp_flag);
                     check(f ? "R4 R5 value" : "R5 value", cap(ch), exp_val);
                     check("R9 other flag", cap_flag[1-ch], 0);
                     check("R9 other value", cap(1-ch), 0);
                     check("R8 irq", irq, exp_flag);
                     if (exp_flag) begin
                        clr[ch] = 1'b1;
                        tick();
                        clr[ch] = 1'b0;
                        check("R6 clear", cap_flag[ch], 0);
                        check("R8 irq low", irq, 0);
                        exp_flag = 1'b0;
                     end
                  end
               end
            end
         end
      end

      // R4: short glitch rejected with the filter on
      fall = '0; filt = 2'b01; evt = '0;
      do_reset();
      pin[0] = 1'b1;
      ticks(3);
      pin[0] = 1'b0;
      ticks(12);
      check("R4 glitch flag", cap_flag[0], 0);
      check("R4 glitch value", cap(0), 0);
      pin[0] = 1'b1;
      t = tmr;
      ticks(12);
      check("R4 filtered latency", cap(0), t + TW'(6));
      pin[0] = 1'b0;
      ticks(10);

      // R10: one-cycle pulse with the filter off
      filt = '0;
      do_reset();
      pin[0] = 1'b1;
      t = tmr;
      tick();
      pin[0] = 1'b0;
      ticks(10);
      check("R10 flag", cap_flag[0], 1);
      check("R10 value", cap(0), t + TW'(3));

      // R7: overwrite while flag still set
      pin[0] = 1'b1;
      t2 = tmr;
      ticks(10);
      check("R7 overwrite flag", cap_flag[0], 1);
      check("R7 overwrite value", cap(0), t2 + TW'(3));
      pin[0] = 1'b0;
      ticks(10);

      // R7: capture and clear in the same cycle
      pin[0] = 1'b1;
      t = tmr;
      ticks(3);
      clr[0] = 1'b1;
      tick();
      clr[0] = 1'b0;
      check("R7 collide flag", cap_flag[0], 1);
      check("R7 collide value", cap(0), t + TW'(3));
      clr[0] = 1'b1;
      tick();
      clr[0] = 1'b0;
      check("R6 clear after collide", cap_flag[0], 0);
      pin[0] = 1'b0;
      ticks(10);

      // R9: both channels running with different settings
      fall = 2'b10; filt = 2'b10; evt = '0;
      do_reset();
      pin = 2'b11;
      t = tmr;
      ticks(10);
      check("R9 ch0 rise flag", cap_flag[0], 1);
      check("R9 ch0 rise value", cap(0), t + TW'(3));
      check("R9 ch1 idle flag", cap_flag[1], 0);
      pin = 2'b00;
      t2 = tmr;
      ticks(10);
      check("R9 ch1 fall flag", cap_flag[1], 1);
      check("R9 ch1 fall value", cap(1), t2 + TW'(6));
      check("R9 ch0 kept value", cap(0), t + TW'(3));
      check("R8 irq both", irq, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule